// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a serial memory device on a two-wire bus. A fast system clock samples the clock and data lines. The block finds start and stop conditions and shifts in bytes on rising edges of the bus clock. It compares each device byte with a fixed prefix and three strap pins, and it acknowledges by pulling the data line low through an open-drain enable. It never drives the data line high.

After a write-addressed device byte, the block takes a 16-bit word address in two bytes and then any number of data bytes. Each data byte goes out to a memory-side datapath as a write strobe with its address. A commit pulse follows at the stop. Read-addressed transactions fetch bytes from the datapath and shift them out most significant bit first. Reading continues for as long as the master acknowledges. Random reads, current-address reads and sequential reads all share one internal address pointer.

While the datapath reports that an internal write cycle is running, device bytes get no acknowledge. A master can therefore poll until the device answers again.

Top module: `twi_mem_slave`

## Requirements
- R1: While `rst` is high, and after it is released with the bus idle, `sda_oe_o`, `mem_wr_o`, `mem_rd_o` and `mem_commit_o` are all low.
- R2: A device byte whose bits 7..4 are 1010 and whose bits 3..1 equal `strap_i` is acknowledged: `sda_oe_o` is high through the ninth clock. Bit 0 = 0 selects write and bit 0 = 1 selects read.
- R3: A device byte with a different prefix or strap gets no acknowledge. Every later byte up to the next start is ignored: no acknowledge and no memory strobe.
- R4: While `wr_busy_i` is high, a matching device byte gets no acknowledge and starts no read. Once `wr_busy_i` is low, the same byte is acknowledged.
- R5: A write transaction loads the high address byte first, then the low byte, and acknowledges both. Each data byte is acknowledged and produces a single-cycle `mem_wr_o` with the byte on `mem_wdata_o` and its address on `mem_addr_o`.
- R6: Consecutive data bytes in one write step only the low 7 address bits. The byte after offset 127 goes to offset 0 of the same page.
- R7: A stop after at least one data byte produces a single-cycle `mem_commit_o`. A write transaction that carries only address bytes commits nothing.
- R8: In a random read (write with address bytes, repeated start, read device byte), the block issues `mem_rd_o` at the loaded address. It then shifts out `mem_rdata_i` MSB first, one bit per clock.
- R9: In a sequential read, each master acknowledge fetches the next address, and the full 16-bit address wraps from 0xFFFF to 0x0000. A no-acknowledge ends the read with no further fetch.
- R10: A current-address read uses the last address accessed plus one. After a write this stays inside the page; after a read it is the full address plus one.
- R11: A start seen in any state restarts device-byte reception. Write data taken before it is not committed.
- R12: `sda_oe_o` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_oe_o | output | 1 | Pull the data line low when high |
| strap_i | input | 3 | Chip-select strap value compared with device byte bits 3..1 |
| wr_busy_i | input | 1 | Datapath internal write cycle in progress |
| mem_wr_o | output | 1 | Single-cycle write strobe for one data byte |
| mem_rd_o | output | 1 | Single-cycle read fetch strobe |
| mem_addr_o | output | ADDR_W | Byte address for the current strobe |
| mem_wdata_o | output | 8 | Write data, valid with `mem_wr_o` |
| mem_rdata_i | input | 8 | Read data, valid from the cycle after `mem_rd_o` |
| mem_commit_o | output | 1 | Single-cycle pulse: start the internal write cycle |

## Verification
The assertions assume that the bus clock stays high and stays low for well over the synchronizer latency (three system clocks). They also assume that the master changes the data line only in the middle of a low phase, apart from start and stop. The stimulus drives every line on a quarter-period grid of five system clocks and only issues start or stop when the clock is high. The assertions also rely on `mem_rdata_i` holding its value from the cycle after each fetch until the next one. The bench memory model meets this with a register that loads only on `mem_rd_o`.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } bus_state_e;

    typedef enum logic [2:0] {
        PTR_HOLD,
        PTR_HI,
        PTR_LO,
        PTR_PAGE,
        PTR_FULL
    } ptr_op_e;

    // events decoded from the synchronized bus lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic dev_match(input logic [6:0] hdr, input logic [2:0] strap);
        return (hdr[6:3] == DEV_PREFIX) && (hdr[2:0] == strap);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_d;
        ev_o.scl_fall = ~scl_s & scl_d;
        ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_op_e           op_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam int                HI_W     = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] FULL_ONE = 1;

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] full_next;

    assign full_next = ptr_q + FULL_ONE;

    generate
        if (PAGE_BITS >= ADDR_W) begin : g_flat
            assign page_next = full_next;
        end else begin : g_paged
            localparam logic [PAGE_BITS-1:0] PAGE_ONE = 1;
            logic [PAGE_BITS-1:0] low_next;
            assign low_next  = ptr_q[PAGE_BITS-1:0] + PAGE_ONE;
            assign page_next = {ptr_q[ADDR_W-1:PAGE_BITS], low_next};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            case (op_i)
                PTR_HI:   ptr_q <= {byte_i[HI_W-1:0], ptr_q[7:0]};
                PTR_LO:   ptr_q <= {ptr_q[ADDR_W-1:8], byte_i};
                PTR_PAGE: ptr_q <= page_next;
                PTR_FULL: ptr_q <= full_next;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/twi_txn_fsm.sv
module twi_txn_fsm
    import twi_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev_i,
    input  logic [2:0] strap_i,
    input  logic       wr_busy_i,
    input  logic [7:0] rdata_i,
    output logic       sda_oe_o,
    output ptr_op_e    ptr_op_o,
    output logic [7:0] byte_o,
    output logic       mem_wr_o,
    output logic       mem_rd_o,
    output logic       mem_commit_o
);

    bus_state_e state;
    logic [2:0] cnt;
    logic [6:0] rx_sh;
    logic [6:0] tx_sh;
    logic       oe_q;
    logic       rw_q;
    logic       wrote_q;
    logic       ack_phase;
    logic       master_ack;

    logic [7:0] byte_next;
    logic       last_bit;
    logic       dev_ok;

    assign byte_next = {rx_sh, ev_i.sda};
    assign last_bit  = ev_i.scl_rise && (cnt == 3'd7);
    assign dev_ok    = dev_match(byte_next[7:1], strap_i) && !wr_busy_i;

    // strobes fire in the cycle the byte completes; the pointer moves at that edge
    always_comb begin
        mem_wr_o = 1'b0;
        mem_rd_o = 1'b0;
        ptr_op_o = PTR_HOLD;
        case (state)
            ST_DEV: begin
                if (last_bit && dev_ok && byte_next[0]) begin
                    mem_rd_o = 1'b1;
                    ptr_op_o = PTR_FULL;
                end
            end
            ST_AHI:  if (last_bit) ptr_op_o = PTR_HI;
            ST_ALO:  if (last_bit) ptr_op_o = PTR_LO;
            ST_WDAT: begin
                if (last_bit) begin
                    mem_wr_o = 1'b1;
                    ptr_op_o = PTR_PAGE;
                end
            end
            ST_RACK: begin
                if (ev_i.scl_rise && !ev_i.sda) begin
                    mem_rd_o = 1'b1;
                    ptr_op_o = PTR_FULL;
                end
            end
            default: ;
        endcase
    end

    assign mem_commit_o = ev_i.stop && wrote_q;
    assign byte_o       = byte_next;
    assign sda_oe_o     = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            oe_q       <= 1'b0;
            rw_q       <= 1'b0;
            wrote_q    <= 1'b0;
            ack_phase  <= 1'b0;
            master_ack <= 1'b0;
        end else if (ev_i.start) begin
            state     <= ST_DEV;
            cnt       <= '0;
            oe_q      <= 1'b0;
            wrote_q   <= 1'b0;
            ack_phase <= 1'b0;
        end else if (ev_i.stop) begin
            state     <= ST_IDLE;
            oe_q      <= 1'b0;
            wrote_q   <= 1'b0;
            ack_phase <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (ev_i.scl_rise) begin
                        rx_sh <= byte_next[6:0];
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            case (state)
                                ST_DEV: begin
                                    if (dev_ok) begin
                                        state <= ST_DEV_ACK;
                                        rw_q  <= byte_next[0];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_AHI:  state <= ST_AHI_ACK;
                                ST_ALO:  state <= ST_ALO_ACK;
                                default: begin
                                    state   <= ST_WDAT_ACK;
                                    wrote_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                    if (ev_i.scl_fall) begin
                        if (!ack_phase) begin
                            oe_q      <= 1'b1;
                            ack_phase <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            cnt       <= '0;
                            oe_q      <= 1'b0;
                            case (state)
                                ST_DEV_ACK: begin
                                    if (rw_q) begin
                                        state <= ST_RDAT;
                                        tx_sh <= rdata_i[6:0];
                                        oe_q  <= ~rdata_i[7];
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end
                                ST_AHI_ACK: state <= ST_ALO;
                                default:    state <= ST_WDAT;
                            endcase
                        end
                    end
                end
                ST_RDAT: begin
                    if (ev_i.scl_fall) begin
                        if (cnt == 3'd7) begin
                            state <= ST_RACK;
                            oe_q  <= 1'b0;
                            cnt   <= '0;
                        end else begin
                            oe_q  <= ~tx_sh[6];
                            tx_sh <= {tx_sh[5:0], 1'b0};
                            cnt   <= cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_i.scl_rise) begin
                        master_ack <= ~ev_i.sda;
                    end
                    if (ev_i.scl_fall) begin
                        if (master_ack) begin
                            state <= ST_RDAT;
                            tx_sh <= rdata_i[6:0];
                            oe_q  <= ~rdata_i[7];
                            cnt   <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              wr_busy_i,
    output logic              mem_wr_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_commit_o
);

    line_ev_t   line_ev;
    ptr_op_e    ptr_op;
    logic [7:0] rx_byte;
    logic       bus_start;

    assign bus_start = line_ev.start;

    twi_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (line_ev)
    );

    twi_txn_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (line_ev),
        .strap_i     (strap_i),
        .wr_busy_i   (wr_busy_i),
        .rdata_i     (mem_rdata_i),
        .sda_oe_o    (sda_oe_o),
        .ptr_op_o    (ptr_op),
        .byte_o      (rx_byte),
        .mem_wr_o    (mem_wr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_commit_o(mem_commit_o)
    );

    twi_addr_ptr #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op_i  (ptr_op),
        .byte_i(rx_byte),
        .ptr_o (mem_addr_o)
    );

    assign mem_wdata_o = rx_byte;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              mem_wr_o,
    input logic              mem_rd_o,
    input logic              mem_commit_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              bus_start
);

    localparam logic [PAGE_BITS-1:0] PAGE_ONE = 1;
    localparam logic [ADDR_W-1:0]    FULL_ONE = 1;

    logic                 wr_seen;
    logic                 rd_seen;
    logic [ADDR_W-1:0]    wr_last;
    logic [ADDR_W-1:0]    rd_last;
    logic [PAGE_BITS-1:0] wr_low_next;
    logic [ADDR_W-1:0]    rd_next;

    always_ff @(posedge clk) begin
        if (rst || bus_start) begin
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            wr_last <= '0;
            rd_last <= '0;
        end else begin
            if (mem_wr_o) begin
                wr_seen <= 1'b1;
                wr_last <= mem_addr_o;
            end
            if (mem_rd_o) begin
                rd_seen <= 1'b1;
                rd_last <= mem_addr_o;
            end
        end
    end

    assign wr_low_next = wr_last[PAGE_BITS-1:0] + PAGE_ONE;
    assign rd_next     = rd_last + FULL_ONE;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !mem_wr_o && !mem_rd_o && !mem_commit_o));

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

    // R7
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_commit_o |=> !mem_commit_o);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_o && (mem_rd_o || mem_commit_o)));

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && wr_seen && !bus_start) |->
        ((mem_addr_o[ADDR_W-1:PAGE_BITS] == wr_last[ADDR_W-1:PAGE_BITS]) &&
         (mem_addr_o[PAGE_BITS-1:0] == wr_low_next)));

    // R9
    seq_read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && rd_seen && !bus_start) |-> (mem_addr_o == rd_next));

endmodule

bind twi_mem_slave twi_mem_slave_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .mem_wr_o    (mem_wr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_commit_o(mem_commit_o),
    .mem_addr_o  (mem_addr_o),
    .bus_start   (bus_start)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;

    localparam int         Q     = 5;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    // {address, data} pairs for byte write then random read back
    localparam logic [23:0] VEC [4] = '{24'h0000_3C, 24'h1234_A7, 24'hBEEF_01, 24'h7FFF_F0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        bus_sda;
    logic        sda_oe;
    logic        wr_busy = 1'b0;
    logic        mem_wr;
    logic        mem_rd;
    logic        mem_commit;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  rdata_q = 8'h00;
    logic        oe_prev = 1'b0;

    int checks = 0;
    int errors = 0;
    int wcnt   = 0;
    int rcnt   = 0;
    int ccnt   = 0;
    int oe_bad = 0;
    bit done   = 1'b0;

    logic [15:0] wlog_a [16];
    logic [7:0]  wlog_d [16];
    logic [15:0] rlog_a [16];

    always #10 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe;

    twi_mem_slave u_twi_mem_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (bus_sda),
        .sda_oe_o    (sda_oe),
        .strap_i     (STRAP),
        .wr_busy_i   (wr_busy),
        .mem_wr_o    (mem_wr),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (rdata_q),
        .mem_commit_o(mem_commit)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // memory-side model and output monitors
    always @(posedge clk) begin
        if (mem_rd) rdata_q <= pat(mem_addr);
        oe_prev <= sda_oe;
        if (!rst) begin
            if (mem_wr) begin
                wlog_a[wcnt % 16] <= mem_addr;
                wlog_d[wcnt % 16] <= mem_wdata;
                wcnt <= wcnt + 1;
            end
            if (mem_rd) begin
                rlog_a[rcnt % 16] <= mem_addr;
                rcnt <= rcnt + 1;
            end
            if (mem_commit) ccnt <= ccnt + 1;
            if (m_scl && (sda_oe !== oe_prev)) oe_bad <= oe_bad + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic v);
        m_scl = 1'b0;
        tick(Q);
        m_sda = b;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        v = bus_sda;
        tick(Q);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic v;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], v);
        clk_bit(1'b1, v);
        ack = !v;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, v);
            b[i] = v;
        end
        clk_bit(!mack, v);
    endtask

    task automatic bus_start();
        m_scl = 1'b0;
        tick(Q);
        m_sda = 1'b1;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_scl = 1'b0;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        tick(2 * Q);
    endtask

    initial begin
        bit          ack;
        logic [7:0]  b;
        logic [15:0] a;
        logic [7:0]  d;
        int          w0;
        int          r0;
        int          c0;

        tick(6);
        chk("R1", "oe in reset", int'(sda_oe), 0);
        chk("R1", "strobes in reset", int'({mem_wr, mem_rd, mem_commit}), 0);
        rst = 1'b0;
        tick(20);
        chk("R1", "oe idle", int'(sda_oe), 0);
        chk("R1", "no strobes idle", wcnt + rcnt + ccnt, 0);

        // vector walk: byte write, then random read of the same address
        for (int k = 0; k < 4; k++) begin
            a  = VEC[k][23:8];
            d  = VEC[k][7:0];
            w0 = wcnt;
            c0 = ccnt;
            r0 = rcnt;
            bus_start();
            send_byte(DEV_W, ack);  chk("R2", "dev write ack", int'(ack), 1);
            send_byte(a[15:8], ack); chk("R5", "addr hi ack", int'(ack), 1);
            send_byte(a[7:0], ack);  chk("R5", "addr lo ack", int'(ack), 1);
            send_byte(d, ack);       chk("R5", "data ack", int'(ack), 1);
            bus_stop();
            tick(4);
            chk("R5", "write count", wcnt - w0, 1);
            chk("R5", "write addr", int'(wlog_a[w0 % 16]), int'(a));
            chk("R5", "write data", int'(wlog_d[w0 % 16]), int'(d));
            chk("R7", "commit after data", ccnt - c0, 1);

            bus_start();
            send_byte(DEV_W, ack);
            send_byte(a[15:8], ack);
            send_byte(a[7:0], ack);
            bus_start();
            send_byte(DEV_R, ack);   chk("R2", "dev read ack", int'(ack), 1);
            recv_byte(1'b0, b);
            bus_stop();
            tick(4);
            chk("R8", "read data", int'(b), int'(pat(a)));
            chk("R8", "read addr", int'(rlog_a[r0 % 16]), int'(a));
            chk("R7", "no commit for dummy write", ccnt - c0, 1);
        end

        // R6: page write crossing the page end wraps inside the page
        w0 = wcnt;
        c0 = ccnt;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h12, ack);
        send_byte(8'h7E, ack);
        for (int j = 0; j < 4; j++) begin
            send_byte(8'hD0 + 8'(j), ack);
            chk("R6", "page data ack", int'(ack), 1);
        end
        bus_stop();
        tick(4);
        chk("R6", "page write count", wcnt - w0, 4);
        for (int j = 0; j < 4; j++) begin
            chk("R6", "page addr", int'(wlog_a[(w0 + j) % 16]), 'h1200 + ((8'h7E + j) % 128));
            chk("R6", "page data", int'(wlog_d[(w0 + j) % 16]), 'hD0 + j);
        end
        chk("R7", "one commit for page", ccnt - c0, 1);

        // R10: current address reads after the page write
        r0 = rcnt;
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        bus_stop();
        tick(4);
        chk("R10", "current addr after write", int'(rlog_a[r0 % 16]), 'h1202);
        chk("R10", "current data after write", int'(b), int'(pat(16'h1202)));
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        bus_stop();
        tick(4);
        chk("R10", "current addr after read", int'(rlog_a[(r0 + 1) % 16]), 'h1203);

        // R9: sequential read across the top of the address space
        r0 = rcnt;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'hFF, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b1, b); chk("R9", "seq byte 0", int'(b), int'(pat(16'hFFFE)));
        recv_byte(1'b1, b); chk("R9", "seq byte 1", int'(b), int'(pat(16'hFFFF)));
        recv_byte(1'b0, b); chk("R9", "seq byte 2", int'(b), int'(pat(16'h0000)));
        bus_stop();
        tick(20);
        chk("R9", "fetches end at nack", rcnt - r0, 3);
        chk("R9", "wrap addr", int'(rlog_a[(r0 + 2) % 16]), 'h0000);

        // R3: mismatched strap and prefix
        w0 = wcnt;
        bus_start();
        send_byte(8'hA2, ack); chk("R3", "strap mismatch nack", int'(ack), 0);
        send_byte(8'h00, ack); chk("R3", "later byte ignored", int'(ack), 0);
        send_byte(8'h10, ack);
        send_byte(8'h77, ack); chk("R3", "data ignored", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'h2A, ack); chk("R3", "prefix mismatch nack", int'(ack), 0);
        bus_stop();
        tick(4);
        chk("R3", "no write strobe", wcnt - w0, 0);

        // R4: busy polling
        r0 = rcnt;
        c0 = ccnt;
        wr_busy = 1'b1;
        bus_start();
        send_byte(DEV_W, ack); chk("R4", "busy write nack", int'(ack), 0);
        bus_start();
        send_byte(DEV_R, ack); chk("R4", "busy read nack", int'(ack), 0);
        bus_stop();
        tick(4);
        chk("R4", "no fetch while busy", rcnt - r0, 0);
        wr_busy = 1'b0;
        bus_start();
        send_byte(DEV_W, ack); chk("R4", "ack after busy", int'(ack), 1);
        bus_stop();
        tick(4);
        chk("R7", "no commit without data", ccnt - c0, 0);

        // R11: repeated start after a data byte discards the write
        w0 = wcnt;
        c0 = ccnt;
        r0 = rcnt;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h03, ack);
        send_byte(8'h00, ack);
        send_byte(8'h11, ack);
        bus_start();
        send_byte(DEV_R, ack); chk("R11", "dev byte after restart", int'(ack), 1);
        recv_byte(1'b0, b);
        bus_stop();
        tick(4);
        chk("R11", "no commit after restart", ccnt - c0, 0);
        chk("R11", "read follows aborted write", int'(rlog_a[r0 % 16]), 'h0301);
        chk("R11", "read data", int'(b), int'(pat(16'h0301)));

        chk("R12", "oe changes while clock high", oe_bad, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule